// File: doc/BRIEF.md
# Byte-Wide Serial Memory Bus Front End

This block is the device-side interface logic of a byte-wide serial access memory. One shared 8-bit port carries commands, address bytes and write data. The block tells them apart by the levels of two steering strobes at the moment the active-low write strobe returns high. It keeps a command register and a three-byte address register. Write data bytes go out as single-cycle pulses on a data path. Read data is presented through a column counter that steps on every falling read strobe.

Array operations are not modelled. Instead, a read, program or erase runs a busy period of fixed length. During that period an open-drain ready/busy pin is pulled low and the write strobes are refused. The block also handles chip-enable standby during reads, with chip-enable ignored while busy. A write-protect input stops program and erase from starting. All strobes are sampled on a system clock that is faster than the strobes, and edges are found by comparing each strobe with its value on the previous clock.

Top module: `nand_bus_front`

## Requirements
- R1: A write-strobe rising edge accepted with the command strobe high and the address strobe low loads the port byte into `cmdReg`, restarts address collection and clears `protoErr`. An edge is accepted only while `ceN` is low and the block is not busy.
- R2: An accepted edge with only the address strobe high stores the byte as an address byte. The first goes to the column byte, the second to `rowAddr[7:0]` and the third to `rowAddr[15:8]`. Any later address bytes are dropped until a new command is latched.
- R3: An accepted edge with both steering strobes low raises `dataValid` for exactly one clock, with the port byte on `dataByte`.
- R4: An accepted edge with both steering strobes high leaves `cmdReg` and the address unchanged and sets `protoErr`.
- R5: The read command (0x00) followed by its third address byte starts a busy period of READ_LAT clocks. When the period ends, `colAddr` is loaded with the column byte.
- R6: Each falling edge of `rdEnN` while `ceN` is low, the block is ready and it is not in standby adds one to `colAddr`. `ioOut` always shows the `arrayData` byte that the array returns for `colAddr`.
- R7: Program-confirm (0x10) or erase-confirm (0xD0) starts a busy period of PROG_LAT clocks when `protN` is high. When `protN` is low, the command is latched but no busy period starts.
- R8: `rbPullLow` is high for exactly the clocks of a busy period and low at all other times.
- R9: After a read has started and the block is ready, `ceN` high puts the block into `standby`. `ceN` low takes it out again.
- R10: While busy, `ceN` high does not cause standby. If `ceN` is still high when the busy period ends, standby is entered then.
- R11: `ioOe` is high only while `ceN` and `rdEnN` are both low and the block is not in standby.
- R12: Write-strobe edges that arrive while busy or while `ceN` is high change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the strobes |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Chip enable, active low |
| cmdStrobe | input | 1 | Steers written bytes to the command register |
| addrStrobe | input | 1 | Steers written bytes to the address register |
| wrEnN | input | 1 | Write strobe, active low, captures on rising edge |
| rdEnN | input | 1 | Read strobe, active low, steps column on falling edge |
| protN | input | 1 | Write protect, low blocks program and erase |
| ioIn | input | 8 | Byte driven onto the shared port |
| arrayData | input | 8 | Byte returned by the array for `colAddr` |
| ioOut | output | 8 | Byte driven onto the shared port |
| ioOe | output | 1 | Output enable for the port drivers |
| rbPullLow | output | 1 | Pulls the open-drain ready/busy line low while busy |
| standby | output | 1 | Standby state |
| protoErr | output | 1 | Both steering strobes were seen high on a write |
| cmdReg | output | 8 | Last latched command |
| colAddr | output | 8 | Column counter |
| rowAddr | output | 16 | Row address bytes |
| dataByte | output | 8 | Last write data byte |
| dataValid | output | 1 | One-clock pulse for each write data byte |

## Verification
Two events can meet in a single clock. The first is the end of a busy period together with a high `ceN`, which has to turn into standby in the clock right after release. The bench raises `ceN` straight after the third read address byte, confirms that standby stays low for the whole busy period, and then expects standby together with the freshly loaded column. The second is a write-strobe edge that lands inside a program busy period: the bench sends a command during the busy window and expects `cmdReg` to keep the confirm code.

// File: rtl/nbf_pkg.sv
package nbf_pkg;
  localparam int DW = 8;
  localparam int ADDR_BYTES = 3;
  localparam logic [DW-1:0] CMD_READ  = 8'h00;
  localparam logic [DW-1:0] CMD_PROG  = 8'h10;
  localparam logic [DW-1:0] CMD_ERASE = 8'hD0;

  typedef struct packed {
    logic latchCmd;
    logic latchAddr;
    logic latchData;
    logic incCol;
    logic loadCol;
  } nbf_strobe_t;
endpackage

// File: rtl/nbf_ctrl.sv
module nbf_ctrl
  import nbf_pkg::*;
#(
  parameter int READ_LAT = 8,
  parameter int PROG_LAT = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ceN,
  input  logic          cmdStrobe,
  input  logic          addrStrobe,
  input  logic          wrEnN,
  input  logic          rdEnN,
  input  logic          protN,
  input  logic [DW-1:0] ioIn,
  output nbf_strobe_t   strb,
  output logic [1:0]    addrIdx,
  output logic          busy,
  output logic          standby,
  output logic          protoErr
);
  localparam int MAXL = (READ_LAT > PROG_LAT) ? READ_LAT : PROG_LAT;
  localparam int CW = $clog2(MAXL + 1);

  logic wePrev, rePrev;
  logic busyIsRead, readMode, readActive;
  logic [CW-1:0] busyCnt;
  logic weRise, reFall, wrEvent, bothHigh, readGo, progGo, isStartOp;

  assign weRise    = !wePrev && wrEnN;
  assign reFall    = rePrev && !rdEnN;
  assign wrEvent   = weRise && !ceN && !busy;
  assign bothHigh  = wrEvent && cmdStrobe && addrStrobe;
  assign isStartOp = (ioIn == CMD_PROG) || (ioIn == CMD_ERASE);

  always_comb begin
    strb.latchCmd  = wrEvent && cmdStrobe && !addrStrobe;
    strb.latchAddr = wrEvent && addrStrobe && !cmdStrobe && (addrIdx < 2'(ADDR_BYTES));
    strb.latchData = wrEvent && !cmdStrobe && !addrStrobe;
    strb.incCol    = reFall && !ceN && !busy && !standby;
    strb.loadCol   = busy && busyIsRead && (busyCnt == '0);
  end

  assign readGo = strb.latchAddr && readMode && (addrIdx == 2'(ADDR_BYTES - 1));
  assign progGo = strb.latchCmd && isStartOp && protN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wePrev <= 1'b1;
      rePrev <= 1'b1;
    end else begin
      wePrev <= wrEnN;
      rePrev <= rdEnN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      busyIsRead <= 1'b0;
      busyCnt    <= '0;
    end else if (busy) begin
      if (busyCnt == '0) busy <= 1'b0;
      else               busyCnt <= busyCnt - 1'b1;
    end else if (readGo) begin
      busy       <= 1'b1;
      busyIsRead <= 1'b1;
      busyCnt    <= CW'(READ_LAT - 1);
    end else if (progGo) begin
      busy       <= 1'b1;
      busyIsRead <= 1'b0;
      busyCnt    <= CW'(PROG_LAT - 1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrIdx    <= '0;
      readMode   <= 1'b0;
      readActive <= 1'b0;
      protoErr   <= 1'b0;
      standby    <= 1'b0;
    end else begin
      if (strb.latchCmd) begin
        addrIdx    <= '0;
        readMode   <= (ioIn == CMD_READ);
        readActive <= 1'b0;
        protoErr   <= 1'b0;
      end else begin
        if (strb.latchAddr) addrIdx <= addrIdx + 1'b1;
        if (readGo)         readActive <= 1'b1;
        if (bothHigh)       protoErr <= 1'b1;
      end
      if (!ceN)                            standby <= 1'b0;
      else if (readActive && !busy)        standby <= 1'b1;
    end
  end
endmodule

// File: rtl/nbf_datapath.sv
module nbf_datapath
  import nbf_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  nbf_strobe_t     strb,
  input  logic [1:0]      addrIdx,
  input  logic [DW-1:0]   ioIn,
  input  logic [DW-1:0]   arrayData,
  output logic [DW-1:0]   cmdReg,
  output logic [DW-1:0]   colAddr,
  output logic [2*DW-1:0] rowAddr,
  output logic [DW-1:0]   dataByte,
  output logic            dataValid,
  output logic [DW-1:0]   ioOut
);
  logic [DW-1:0] colByte;

  assign ioOut = arrayData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg    <= '1;
      colByte   <= '0;
      rowAddr   <= '0;
      colAddr   <= '0;
      dataByte  <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= strb.latchData;
      if (strb.latchData) dataByte <= ioIn;
      if (strb.latchCmd)  cmdReg <= ioIn;
      if (strb.latchAddr) begin
        case (addrIdx)
          2'd0:    colByte <= ioIn;
          2'd1:    rowAddr[DW-1:0] <= ioIn;
          default: rowAddr[2*DW-1:DW] <= ioIn;
        endcase
      end
      if (strb.loadCol)     colAddr <= colByte;
      else if (strb.incCol) colAddr <= colAddr + 1'b1;
    end
  end
endmodule

// File: rtl/nand_bus_front.sv
module nand_bus_front
  import nbf_pkg::*;
#(
  parameter int READ_LAT = 8,
  parameter int PROG_LAT = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        cmdStrobe,
  input  logic        addrStrobe,
  input  logic        wrEnN,
  input  logic        rdEnN,
  input  logic        protN,
  input  logic [7:0]  ioIn,
  input  logic [7:0]  arrayData,
  output logic [7:0]  ioOut,
  output logic        ioOe,
  output logic        rbPullLow,
  output logic        standby,
  output logic        protoErr,
  output logic [7:0]  cmdReg,
  output logic [7:0]  colAddr,
  output logic [15:0] rowAddr,
  output logic [7:0]  dataByte,
  output logic        dataValid
);
  nbf_strobe_t strb;
  logic [1:0]  addrIdx;
  logic        busy;

  nbf_ctrl #(.READ_LAT(READ_LAT), .PROG_LAT(PROG_LAT)) ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cmdStrobe(cmdStrobe),
    .addrStrobe(addrStrobe), .wrEnN(wrEnN), .rdEnN(rdEnN), .protN(protN),
    .ioIn(ioIn), .strb(strb), .addrIdx(addrIdx), .busy(busy),
    .standby(standby), .protoErr(protoErr)
  );

  nbf_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .addrIdx(addrIdx), .ioIn(ioIn),
    .arrayData(arrayData), .cmdReg(cmdReg), .colAddr(colAddr),
    .rowAddr(rowAddr), .dataByte(dataByte), .dataValid(dataValid),
    .ioOut(ioOut)
  );

  assign rbPullLow = busy;
  assign ioOe      = !ceN && !rdEnN && !standby;
endmodule

// File: rtl/nbf_checker.sv
module nbf_checker
  import nbf_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       ceN,
  input logic       cmdStrobe,
  input logic       addrStrobe,
  input logic       wrEnN,
  input logic       rdEnN,
  input logic       protN,
  input logic [7:0] ioIn,
  input logic       rbPullLow,
  input logic       standby,
  input logic       protoErr,
  input logic       dataValid,
  input logic [7:0] colAddr
);
  assert_both_strobes_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(wrEnN) && !ceN && !rbPullLow && cmdStrobe && addrStrobe) |=> protoErr);

  assert_data_steer_R3: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> $past(!cmdStrobe && !addrStrobe && !ceN));

  assert_col_change_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(colAddr) |-> ($past($fell(rdEnN)) || $fell(rbPullLow)));

  assert_protect_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(wrEnN) && !ceN && !rbPullLow && cmdStrobe && !addrStrobe && !protN &&
     ((ioIn == CMD_PROG) || (ioIn == CMD_ERASE))) |=> !rbPullLow);

  assert_no_busy_standby_R10: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> !rbPullLow);

  assert_busy_blocks_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rbPullLow && $rose(wrEnN)) |=> !dataValid);
endmodule

bind nand_bus_front nbf_checker chk_i (
  .clk(clk), .rstN(rstN), .ceN(ceN), .cmdStrobe(cmdStrobe),
  .addrStrobe(addrStrobe), .wrEnN(wrEnN), .rdEnN(rdEnN), .protN(protN),
  .ioIn(ioIn), .rbPullLow(rbPullLow), .standby(standby),
  .protoErr(protoErr), .dataValid(dataValid), .colAddr(colAddr)
);

// File: tb/nand_bus_front_tb_top.sv
module nand_bus_front_tb_top;
  localparam int READ_LAT = 8;
  localparam int PROG_LAT = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b0, cmdStrobe = 1'b0, addrStrobe = 1'b0;
  logic wrEnN = 1'b1, rdEnN = 1'b1, protN = 1'b1;
  logic [7:0] ioIn = 8'h00;
  logic [7:0] arrayData, ioOut, cmdReg, colAddr, dataByte;
  logic [15:0] rowAddr;
  logic ioOe, rbPullLow, standby, protoErr, dataValid;

  int nChecks = 0, nFails = 0;
  int busyCnt = 0, dataCnt = 0;
  logic [7:0] lastData = 8'h00;

  always #10 clk = ~clk;

  assign arrayData = colAddr ^ 8'hA5;

  nand_bus_front #(.READ_LAT(READ_LAT), .PROG_LAT(PROG_LAT)) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cmdStrobe(cmdStrobe),
    .addrStrobe(addrStrobe), .wrEnN(wrEnN), .rdEnN(rdEnN), .protN(protN),
    .ioIn(ioIn), .arrayData(arrayData), .ioOut(ioOut), .ioOe(ioOe),
    .rbPullLow(rbPullLow), .standby(standby), .protoErr(protoErr),
    .cmdReg(cmdReg), .colAddr(colAddr), .rowAddr(rowAddr),
    .dataByte(dataByte), .dataValid(dataValid)
  );

  always @(negedge clk) begin
    if (rbPullLow) busyCnt++;
    if (dataValid) begin dataCnt++; lastData = dataByte; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeByte(input logic cle, input logic ale, input logic [7:0] b);
    @(negedge clk); cmdStrobe = cle; addrStrobe = ale; ioIn = b; wrEnN = 1'b0;
    @(negedge clk);
    @(negedge clk); wrEnN = 1'b1;
    @(negedge clk);
    @(negedge clk); cmdStrobe = 1'b0; addrStrobe = 1'b0;
  endtask

  task automatic waitReady();
    for (int i = 0; i < 200 && rbPullLow; i++) @(negedge clk);
  endtask

  task automatic startRead(input logic [7:0] col);
    writeByte(1, 0, 8'h00);
    writeByte(0, 1, col);
    writeByte(0, 1, 8'h34);
    busyCnt = 0;
    writeByte(0, 1, 8'h12);
  endtask

  task automatic testReset();
    check(rbPullLow == 0, "R8 reset busy", rbPullLow, 0);
    check(ioOe == 0, "R11 reset oe", ioOe, 0);
    check(standby == 0 && protoErr == 0, "R9 reset flags", {standby, protoErr}, 0);
    check(dataValid == 0, "R3 reset valid", dataValid, 0);
  endtask

  task automatic testRead();
    startRead(8'h10);
    check(cmdReg == 8'h00, "R1 command latched", cmdReg, 8'h00);
    check(rbPullLow == 1, "R5 read busy started", rbPullLow, 1);
    waitReady();
    check(busyCnt == READ_LAT, "R8 read busy length", busyCnt, READ_LAT);
    check(rowAddr == 16'h1234, "R2 row order", rowAddr, 16'h1234);
    check(colAddr == 8'h10, "R5 column loaded", colAddr, 8'h10);
    check(ioOe == 0, "R11 oe idle", ioOe, 0);
    @(negedge clk); rdEnN = 1'b0;
    @(negedge clk); @(negedge clk);
    check(colAddr == 8'h11, "R6 column step", colAddr, 8'h11);
    check(ioOut == (8'h11 ^ 8'hA5), "R6 output byte", ioOut, 8'h11 ^ 8'hA5);
    check(ioOe == 1, "R11 oe read", ioOe, 1);
    rdEnN = 1'b1;
    @(negedge clk); @(negedge clk);
    check(ioOe == 0, "R11 oe release", ioOe, 0);
    check(colAddr == 8'h11, "R6 no step on rise", colAddr, 8'h11);
  endtask

  task automatic testExtraAddr();
    busyCnt = 0;
    writeByte(0, 1, 8'h77);
    repeat (3) @(negedge clk);
    check(rowAddr == 16'h1234, "R2 extra address dropped", rowAddr, 16'h1234);
    check(busyCnt == 0, "R2 extra address no busy", busyCnt, 0);
  endtask

  task automatic testStandby();
    @(negedge clk); ceN = 1'b1;
    @(negedge clk); @(negedge clk);
    check(standby == 1, "R9 standby entered", standby, 1);
    rdEnN = 1'b0;
    @(negedge clk);
    check(ioOe == 0, "R11 oe standby", ioOe, 0);
    writeByte(1, 0, 8'h55);
    check(cmdReg == 8'h00, "R12 write ignored ce high", cmdReg, 8'h00);
    rdEnN = 1'b1;
    @(negedge clk); ceN = 1'b0;
    @(negedge clk); @(negedge clk);
    check(standby == 0, "R9 standby left", standby, 0);
  endtask

  task automatic testDataAndProg();
    writeByte(1, 0, 8'h80);
    dataCnt = 0;
    writeByte(0, 0, 8'h5A);
    check(dataCnt == 1 && lastData == 8'h5A, "R3 data pulse", {dataCnt[7:0], lastData}, 16'h015A);
    busyCnt = 0;
    protN = 1'b1;
    writeByte(1, 0, 8'h10);
    check(rbPullLow == 1, "R7 program busy", rbPullLow, 1);
    dataCnt = 0;
    writeByte(1, 0, 8'h00);
    writeByte(0, 0, 8'h33);
    check(cmdReg == 8'h10, "R12 command ignored busy", cmdReg, 8'h10);
    check(dataCnt == 0, "R12 data ignored busy", dataCnt, 0);
    waitReady();
    check(busyCnt == PROG_LAT, "R8 program busy length", busyCnt, PROG_LAT);
  endtask

  task automatic testProtect();
    protN = 1'b0;
    busyCnt = 0;
    writeByte(1, 0, 8'hD0);
    repeat (4) @(negedge clk);
    check(busyCnt == 0, "R7 protected erase blocked", busyCnt, 0);
    check(cmdReg == 8'hD0, "R7 protected command latched", cmdReg, 8'hD0);
    protN = 1'b1;
  endtask

  task automatic testBothHigh();
    writeByte(1, 1, 8'h99);
    check(protoErr == 1, "R4 error set", protoErr, 1);
    check(cmdReg == 8'hD0, "R4 byte discarded", cmdReg, 8'hD0);
    writeByte(1, 0, 8'h70);
    check(protoErr == 0 && cmdReg == 8'h70, "R1 error cleared", {protoErr, cmdReg}, 8'h70);
  endtask

  task automatic testCeDuringBusy();
    startRead(8'h20);
    ceN = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!(rbPullLow && standby), "R10 no standby while busy", standby, 0);
    end
    waitReady();
    check(standby == 0, "R10 standby at release", standby, 0);
    @(negedge clk);
    check(standby == 1, "R10 standby after busy", standby, 1);
    check(colAddr == 8'h20, "R5 column after busy", colAddr, 8'h20);
    @(negedge clk); ceN = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRead();
    testExtraAddr();
    testStandby();
    testDataAndProg();
    testProtect();
    testBothHigh();
    testCeDuringBusy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule